// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Scheduler

This block keeps an asynchronous 256-row DRAM alive. After reset it holds the strobes idle for a parameterized settling time. It then runs a fixed burst of warm-up refresh cycles on its own, without asking for the bus. Only after that burst does it raise a ready flag to the host-side access sequencer. From then on a free-running interval timer marks when each distributed refresh falls due. The interval suits either the standard part, where the whole array must be covered every 4 ms, or the low-power part, where the limit is 32 ms.

Each due refresh adds to a small saturating backlog and raises a request toward the access sequencer. Once the grant arrives, the block takes over the row and column strobes. It works off the whole backlog back to back, then hands the bus back. A build-time switch picks the refresh style:
- In strobe-order mode the column strobe drops ahead of the row strobe, and the DRAM supplies the row itself.
- In row-driven mode the column strobe stays high, and an internal 8-bit row counter is presented on the address lines.

Top module: `dram_refresh_sched`

## Requirements
- R1: After reset, `ras_n` stays high and `ready` stays low for at least `PWRUP_CYC` clock cycles; in reset `ready`, `ref_req` and `ref_own` are 0 and both strobes are 1.
- R2: Once the power-up wait ends, exactly `INIT_REFS` refresh pulses (falling edges of `ras_n`) occur without any grant; `ready` rises when the last one completes and then stays high.
- R3: With `RAS_ONLY`=0, `cas_n` is low at every falling edge of `ras_n` and for the whole time `ras_n` is low; `row_addr` is 0.
- R4: With `RAS_ONLY`=1, `cas_n` is always 1. At the n-th refresh pulse since reset (n counted from 0), `row_addr` equals n mod 256, so it wraps from 255 to 0.
- R5: Before every falling edge, `ras_n` has been high for at least `T_RP` cycles. Every low pulse of `ras_n` lasts exactly `T_RAS` cycles.
- R6: After `ready`, a refresh falls due every `REF_INT` cycles, where `REF_INT` is `REF_INT_LP` when `LOW_POWER`=1 and `REF_INT_STD` otherwise. With a prompt grant, each window of N intervals holds N±1 refresh pulses.
- R7: Due refreshes that find the grant low are counted in a backlog that saturates at `PEND_MAX`. When the grant comes, the backlog is issued back to back, so after a long wait the burst is `PEND_MAX` pulses, plus at most one that falls due during the burst.
- R8: After `ready`, no refresh pulse starts unless `ref_gnt` is high; `ras_n` stays high while the grant is withheld.
- R9: `ref_req` is low before `ready`, is high while a backlog exists, and drops when the backlog is empty. `ref_own` is high whenever `ras_n` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_gnt | input | 1 | Bus handed to the refresh scheduler |
| ready | output | 1 | Power-up and warm-up complete; host may access |
| ref_req | output | 1 | Refresh work outstanding or in progress |
| ref_own | output | 1 | Scheduler is currently driving the strobes |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| row_addr | output | ROW_W | Row address presented during row-driven refresh |

## Verification
Two instances are run side by side:
- The strobe-order standard instance has its grant held off for many intervals and then released. This separates a saturating backlog from an unbounded one, and shows whether refreshes leak out without a grant.
- The row-driven low-power instance answers requests after random latencies from a fixed seed. Counting its pulses over a window tells the two interval settings apart, and running past 256 refreshes exposes the row counter's wrap.

Every strobe edge on both instances is timed against the precharge and pulse-width rules. The column strobe order and the address are checked at each falling edge.

// File: rtl/dram_ref_pkg.sv
package dram_ref_pkg;
  typedef enum logic [2:0] {
    ST_PWR  = 3'd0,
    ST_IDLE = 3'd1,
    ST_PRE  = 3'd2,
    ST_CAS  = 3'd3,
    ST_ACT  = 3'd4
  } ref_state_e;
endpackage

// File: rtl/dram_ref_timer.sv
module dram_ref_timer #(
  parameter int PWRUP_CYC = 12500,
  parameter int REF_INT   = 1950
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic pwr_done,
  output logic tick
);
  localparam int PW = $clog2(PWRUP_CYC + 1);
  localparam int IW = $clog2(REF_INT + 1);

  logic [PW-1:0] pwr_cnt_q, pwr_cnt_d;
  logic          pwr_done_q, pwr_done_d;
  logic [IW-1:0] int_cnt_q, int_cnt_d;
  logic          tick_q, tick_d;

  // power-up settle counter, stops once done
  always_comb begin
    pwr_cnt_d  = pwr_cnt_q;
    pwr_done_d = pwr_done_q;
    if (!pwr_done_q) begin
      if (pwr_cnt_q == PW'(PWRUP_CYC - 1)) pwr_done_d = 1'b1;
      else                                 pwr_cnt_d  = pwr_cnt_q + 1'b1;
    end
  end

  // distributed refresh interval, only while run is high
  always_comb begin
    int_cnt_d = int_cnt_q;
    tick_d    = 1'b0;
    if (run) begin
      if (int_cnt_q == IW'(REF_INT - 1)) begin
        int_cnt_d = '0;
        tick_d    = 1'b1;
      end else begin
        int_cnt_d = int_cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwr_cnt_q  <= '0;
      pwr_done_q <= 1'b0;
      int_cnt_q  <= '0;
      tick_q     <= 1'b0;
    end else begin
      pwr_cnt_q  <= pwr_cnt_d;
      pwr_done_q <= pwr_done_d;
      int_cnt_q  <= int_cnt_d;
      tick_q     <= tick_d;
    end
  end

  assign pwr_done = pwr_done_q;
  assign tick     = tick_q;

  // R6: no due refresh is flagged before the scheduler is running
  a_r6_tick_only_running: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> $past(run));
endmodule

// File: rtl/dram_ref_pending.sv
module dram_ref_pending #(
  parameter int PEND_MAX = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inc,
  input  logic dec,
  output logic nonzero,
  output logic more
);
  localparam int W = $clog2(PEND_MAX + 1);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    case ({inc, dec})
      2'b10:   if (cnt_q != W'(PEND_MAX)) cnt_d = cnt_q + 1'b1;
      2'b01:   if (cnt_q != '0)           cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign nonzero = (cnt_q != '0);
  assign more    = (cnt_q > W'(1));

  // R7: backlog never passes its ceiling
  a_r7_backlog_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= W'(PEND_MAX));
  // R7: a full backlog stays full when another refresh falls due
  a_r7_backlog_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !dec && cnt_q == W'(PEND_MAX)) |=> cnt_q == W'(PEND_MAX));
endmodule

// File: rtl/dram_ref_row.sv
module dram_ref_row #(
  parameter int ROW_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  output logic [ROW_W-1:0] row
);
  logic [ROW_W-1:0] row_q, row_d;

  always_comb begin
    row_d = row_q;
    if (step) row_d = row_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) row_q <= '0;
    else        row_q <= row_d;
  end

  assign row = row_q;

  // R4: row advances by one per refresh, wrapping at the top
  a_r4_row_steps: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> row_q == ROW_W'($past(row_q) + 1'b1));
  a_r4_row_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(row_q));
endmodule

// File: rtl/dram_ref_seq.sv
module dram_ref_seq
  import dram_ref_pkg::*;
#(
  parameter int INIT_REFS = 8,
  parameter int T_RP      = 5,
  parameter int T_CSR     = 2,
  parameter int T_RAS     = 8,
  parameter int RAS_ONLY  = 0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_done,
  input  logic pend_nz,
  input  logic pend_more,
  input  logic gnt,
  output logic ready,
  output logic own,
  output logic act_done,
  output logic ras_n,
  output logic cas_n
);
  localparam int MAXT = (T_RP > T_RAS) ? ((T_RP > T_CSR) ? T_RP : T_CSR)
                                       : ((T_RAS > T_CSR) ? T_RAS : T_CSR);
  localparam int CW = $clog2(MAXT + 1);
  localparam int IW = $clog2(INIT_REFS + 1);

  ref_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [IW-1:0] init_q, init_d;
  logic          ready_q, ready_d;
  logic          done_c;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    init_d  = init_q;
    ready_d = ready_q;
    done_c  = 1'b0;
    case (state_q)
      ST_PWR: begin
        if (pwr_done) begin
          state_d = ST_PRE;
          cnt_d   = '0;
        end
      end
      ST_IDLE: begin
        if (pend_nz && gnt) begin
          state_d = ST_PRE;
          cnt_d   = '0;
        end
      end
      ST_PRE: begin
        if (cnt_q == CW'(T_RP - 1)) begin
          cnt_d   = '0;
          state_d = (RAS_ONLY != 0) ? ST_ACT : ST_CAS;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_CAS: begin
        if (cnt_q == CW'(T_CSR - 1)) begin
          cnt_d   = '0;
          state_d = ST_ACT;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_ACT: begin
        if (cnt_q == CW'(T_RAS - 1)) begin
          cnt_d  = '0;
          done_c = 1'b1;
          if (!ready_q) begin
            if (init_q == IW'(INIT_REFS - 1)) begin
              ready_d = 1'b1;
              state_d = ST_IDLE;
            end else begin
              init_d  = init_q + 1'b1;
              state_d = ST_PRE;
            end
          end else begin
            state_d = pend_more ? ST_PRE : ST_IDLE;
          end
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: state_d = ST_PWR;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_PWR;
      cnt_q   <= '0;
      init_q  <= '0;
      ready_q <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      init_q  <= init_d;
      ready_q <= ready_d;
    end
  end

  assign ready    = ready_q;
  assign act_done = done_c;
  assign own      = (state_q == ST_PRE) || (state_q == ST_CAS) || (state_q == ST_ACT);
  assign ras_n    = (state_q != ST_ACT);
  assign cas_n    = !((RAS_ONLY == 0) && ((state_q == ST_CAS) || (state_q == ST_ACT)));

  // R1: ready never precedes the end of the power-up wait
  a_r1_ready_after_settle: assert property (@(posedge clk) disable iff (!rst_n)
    ready_q |-> pwr_done);
  // R2: once raised, ready stays
  a_r2_ready_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ready_q) |-> ready_q);
  // R8: leaving idle for a refresh requires the grant
  a_r8_start_needs_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PRE && $past(state_q) == ST_IDLE) |-> $past(gnt));
  // R3: in strobe-order mode the row strobe never falls with the column strobe high
  a_r3_cas_leads_ras: assert property (@(posedge clk) disable iff (!rst_n)
    (RAS_ONLY == 0 && $fell(ras_n)) |-> $past(!cas_n));
endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched #(
  parameter int PWRUP_CYC   = 12500,
  parameter int INIT_REFS   = 8,
  parameter int LOW_POWER   = 0,
  parameter int REF_INT_STD = 1950,
  parameter int REF_INT_LP  = 15625,
  parameter int RAS_ONLY    = 0,
  parameter int PEND_MAX    = 4,
  parameter int T_RP        = 5,
  parameter int T_CSR       = 2,
  parameter int T_RAS       = 8,
  parameter int ROW_W       = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_gnt,
  output logic             ready,
  output logic             ref_req,
  output logic             ref_own,
  output logic             ras_n,
  output logic             cas_n,
  output logic [ROW_W-1:0] row_addr
);
  localparam int REF_INT = (LOW_POWER != 0) ? REF_INT_LP : REF_INT_STD;
  localparam int HW      = $clog2(T_RP + 1);
  localparam int LW      = $clog2(T_RAS + 2);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic             pwr_done, tick, pend_nz, pend_more, act_done, rdy, own;
  logic [ROW_W-1:0] row;

  dram_ref_timer #(
    .PWRUP_CYC (PWRUP_CYC),
    .REF_INT   (REF_INT)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .run      (rdy),
    .pwr_done (pwr_done),
    .tick     (tick)
  );

  dram_ref_pending #(
    .PEND_MAX (PEND_MAX)
  ) u_pend (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .inc     (tick),
    .dec     (act_done && rdy),
    .nonzero (pend_nz),
    .more    (pend_more)
  );

  dram_ref_row #(
    .ROW_W (ROW_W)
  ) u_row (
    .clk   (clk),
    .rst_n (rst_int_n),
    .step  (act_done),
    .row   (row)
  );

  dram_ref_seq #(
    .INIT_REFS (INIT_REFS),
    .T_RP      (T_RP),
    .T_CSR     (T_CSR),
    .T_RAS     (T_RAS),
    .RAS_ONLY  (RAS_ONLY)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .pwr_done  (pwr_done),
    .pend_nz   (pend_nz),
    .pend_more (pend_more),
    .gnt       (ref_gnt),
    .ready     (rdy),
    .own       (own),
    .act_done  (act_done),
    .ras_n     (ras_n),
    .cas_n     (cas_n)
  );

  assign ready    = rdy;
  assign ref_own  = own;
  assign ref_req  = rdy && (pend_nz || own);
  assign row_addr = (RAS_ONLY != 0) ? row : '0;

  // strobe run-length counters used only by the timing checks below
  logic [HW-1:0] hi_q, hi_d;
  logic [LW-1:0] lo_q, lo_d;

  always_comb begin
    hi_d = ras_n ? ((hi_q == HW'(T_RP)) ? hi_q : hi_q + 1'b1) : '0;
    lo_d = ras_n ? '0 : ((lo_q == LW'(T_RAS + 1)) ? lo_q : lo_q + 1'b1);
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      hi_q <= HW'(T_RP);
      lo_q <= '0;
    end else begin
      hi_q <= hi_d;
      lo_q <= lo_d;
    end
  end

  // R5: precharge met before each row strobe fall
  a_r5_precharge_met: assert property (@(posedge clk) disable iff (!rst_int_n)
    $fell(ras_n) |-> hi_q >= HW'(T_RP));
  // R5: row strobe pulse width exact
  a_r5_pulse_width: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(ras_n) |-> lo_q == LW'(T_RAS));
  // R9: request is silent until ready
  a_r9_no_req_before_ready: assert property (@(posedge clk) disable iff (!rst_int_n)
    !ready |-> !ref_req);
endmodule

// File: tb/tb_dram_refresh_sched.sv
module tb_dram_refresh_sched;
  localparam int PWR  = 300;
  localparam int INIT = 8;
  localparam int STD  = 100;
  localparam int LP   = 150;
  localparam int TRP  = 5;
  localparam int TCSR = 2;
  localparam int TRAS = 8;
  localparam int PMAX = 4;

  logic       clk;
  logic       rst_n;
  logic       gnt   [2];
  logic       rdy   [2];
  logic       req   [2];
  logic       own   [2];
  logic       ras   [2];
  logic       cas   [2];
  logic [7:0] addr  [2];

  int  n_chk, n_fail, cyc;
  int  hi_run [2];
  int  lo_run [2];
  int  falls  [2];
  int  first_fall [2];
  int  exp_row [2];
  int  lat    [2];
  bit  prev_ras [2];
  bit  prev_rdy [2];
  bit  auto_g [2];
  bit  mon_on, wrap_seen, done;

  initial clk = 1'b0;
  always #4 clk = ~clk;

  dram_refresh_sched #(
    .PWRUP_CYC(PWR), .INIT_REFS(INIT), .LOW_POWER(0), .REF_INT_STD(STD),
    .REF_INT_LP(LP), .RAS_ONLY(0), .PEND_MAX(PMAX), .T_RP(TRP),
    .T_CSR(TCSR), .T_RAS(TRAS), .ROW_W(8)
  ) dut (
    .clk(clk), .rst_n(rst_n), .ref_gnt(gnt[0]), .ready(rdy[0]),
    .ref_req(req[0]), .ref_own(own[0]), .ras_n(ras[0]), .cas_n(cas[0]),
    .row_addr(addr[0])
  );

  dram_refresh_sched #(
    .PWRUP_CYC(PWR), .INIT_REFS(INIT), .LOW_POWER(1), .REF_INT_STD(STD),
    .REF_INT_LP(LP), .RAS_ONLY(1), .PEND_MAX(PMAX), .T_RP(TRP),
    .T_CSR(TCSR), .T_RAS(TRAS), .ROW_W(8)
  ) dut_ro (
    .clk(clk), .rst_n(rst_n), .ref_gnt(gnt[1]), .ready(rdy[1]),
    .ref_req(req[1]), .ref_own(own[1]), .ras_n(ras[1]), .cas_n(cas[1]),
    .row_addr(addr[1])
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  endtask

  function automatic bit in_window(input int v, input int n);
    return (v >= n - 1) && (v <= n + 1);
  endfunction

  // grant responder with random latency
  always @(posedge clk) begin
    #1;
    for (int i = 0; i < 2; i++) begin
      if (auto_g[i]) begin
        if (!req[i]) begin
          gnt[i] = 1'b0;
          lat[i] = int'($urandom % 8);
        end else if (!gnt[i]) begin
          if (lat[i] == 0) gnt[i] = 1'b1;
          else             lat[i] = lat[i] - 1;
        end
      end
    end
  end

  // strobe monitor, sampled mid-cycle
  always @(negedge clk) begin
    if (mon_on) begin
      cyc++;
      for (int i = 0; i < 2; i++) begin
        if (prev_ras[i] && !ras[i]) begin
          chk(hi_run[i] >= TRP, "R5 precharge before fall", hi_run[i], TRP);
          if (i == 0) begin
            chk(cas[i] == 1'b0, "R3 cas low at ras fall", int'(cas[i]), 0);
            chk(addr[i] == 8'd0, "R3 address zero", int'(addr[i]), 0);
          end else begin
            chk(int'(addr[i]) == exp_row[i], "R4 row address", int'(addr[i]), exp_row[i]);
            if (addr[i] == 8'd0 && falls[i] > 0) wrap_seen = 1'b1;
            exp_row[i] = (exp_row[i] + 1) % 256;
          end
          if (falls[i] == 0) first_fall[i] = cyc;
          falls[i]++;
          if (rdy[i]) chk(gnt[i] == 1'b1, "R8 refresh only under grant", int'(gnt[i]), 1);
          hi_run[i] = 0;
          lo_run[i] = 0;
        end else if (!prev_ras[i] && ras[i]) begin
          chk(lo_run[i] == TRAS, "R5 pulse width", lo_run[i], TRAS);
          lo_run[i] = 0;
          hi_run[i] = 0;
        end
        if (ras[i]) hi_run[i]++;
        else        lo_run[i]++;
        if (i == 1) chk(cas[i] == 1'b1, "R4 cas stays high", int'(cas[i]), 1);
        if (i == 0 && !ras[i]) chk(cas[i] == 1'b0, "R3 cas low during pulse", int'(cas[i]), 0);
        if (!rdy[i]) chk(req[i] == 1'b0, "R9 no request before ready", int'(req[i]), 0);
        if (!ras[i]) chk(own[i] == 1'b1, "R9 own while strobing", int'(own[i]), 1);
        if (!prev_rdy[i] && rdy[i]) begin
          chk(falls[i] == INIT, "R2 warm-up refresh count", falls[i], INIT);
          chk(first_fall[i] >= PWR, "R1 power-up wait", first_fall[i], PWR);
        end
        if (prev_rdy[i]) chk(rdy[i] == 1'b1, "R2 ready stays", int'(rdy[i]), 1);
        prev_ras[i] = ras[i];
        prev_rdy[i] = rdy[i];
      end
    end
  end

  initial begin
    int f0, burst, guard;
    void'($urandom(32'd1234));
    n_chk = 0; n_fail = 0; cyc = 0; mon_on = 0; wrap_seen = 0; done = 0;
    for (int i = 0; i < 2; i++) begin
      gnt[i] = 1'b0; hi_run[i] = 0; lo_run[i] = 0; falls[i] = 0;
      first_fall[i] = 0; exp_row[i] = 0; lat[i] = 0;
      prev_ras[i] = 1'b1; prev_rdy[i] = 1'b0;
    end
    auto_g[0] = 1'b0;
    auto_g[1] = 1'b1;
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    for (int i = 0; i < 2; i++) begin
      chk(rdy[i] == 1'b0 && req[i] == 1'b0 && own[i] == 1'b0, "R1 reset outputs idle",
          int'({rdy[i], req[i], own[i]}), 0);
      chk(ras[i] == 1'b1 && cas[i] == 1'b1, "R1 reset strobes high",
          int'({ras[i], cas[i]}), 3);
    end
    rst_n  = 1'b1;
    mon_on = 1'b1;

    guard = 0;
    while (!rdy[0] && guard < 5000) begin @(negedge clk); guard++; end
    chk(rdy[0] == 1'b1, "R2 ready reached", int'(rdy[0]), 1);

    // grant withheld over many intervals: backlog must saturate
    f0 = falls[0];
    repeat (8 * STD) @(negedge clk);
    chk(falls[0] == f0, "R8 no pulse while grant withheld", falls[0] - f0, 0);
    chk(req[0] == 1'b1, "R9 request held with backlog", int'(req[0]), 1);
    @(posedge clk); #1 gnt[0] = 1'b1;
    guard = 0;
    @(negedge clk);
    while (req[0] && guard < 1000) begin @(negedge clk); guard++; end
    burst = falls[0] - f0;
    chk(burst >= PMAX && burst <= PMAX + 1, "R7 saturated burst length", burst, PMAX);
    chk(req[0] == 1'b0, "R9 request drops after burst", int'(req[0]), 0);
    @(posedge clk); #1 gnt[0] = 1'b0;
    auto_g[0] = 1'b1;

    // standard interval with random grant latency
    repeat (STD) @(negedge clk);
    f0 = falls[0];
    repeat (20 * STD) @(negedge clk);
    chk(in_window(falls[0] - f0, 20), "R6 standard interval rate", falls[0] - f0, 20);

    // low-power interval on the row-driven instance
    f0 = falls[1];
    repeat (20 * LP) @(negedge clk);
    chk(in_window(falls[1] - f0, 20), "R6 low-power interval rate", falls[1] - f0, 20);

    guard = 0;
    while (falls[1] < INIT + 262 && guard < 60000) begin @(negedge clk); guard++; end
    chk(falls[1] >= INIT + 262, "R4 enough refreshes for wrap", falls[1], INIT + 262);
    chk(wrap_seen, "R4 row counter wrapped to 0", int'(wrap_seen), 1);
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    finish_run();
  end
endmodule